// File: doc/BRIEF.md
# Graphics Power-Gate Release Sequencer

This block is a small bus master. It takes a graphics engine out of the power-gated state that the chip applies at boot. A one-cycle start pulse makes it walk a fixed list of sixteen steps against three 32-bit control registers.

Each step is one of three kinds:

- a single-bit read-modify-write, which reads the word, flips or forces one bit and writes the word back;
- a bare readback, which flushes the previous write;
- a long timed wait.

The master uses a plain register bus with one transaction in flight at a time. Address, write data and a write or read strobe are held steady until the slave returns ready. Read data is taken in the cycle where ready is high.

The sequence first holds the engine in reset and turns on its block-level gating controllers, then waits. Next it drives the power-switch clamp high through a masked pulse, lifts the boot gating with the override value forced off before the override is engaged, and waits again. Finally it drives the clamp low with a second masked pulse, turns the gating controllers off and releases the engine from reset. Both waits last 50 ms, counted in clock cycles from a clock-frequency parameter. A nonzero override parameter replaces the derived count.

Top module: `pgr_release_seq`

## Requirements
- R1: In reset and in the cycle after it, busy, done, the write strobe and the read strobe are all low.
- R2: Start is taken only while idle. A start pulse during a running sequence does not add, repeat or restart any bus transaction.
- R3: Busy rises in the cycle after an accepted start and stays high until the last step completes. Done is high for exactly one cycle, and busy is low in that cycle.
- R4: Every write step first reads the target address, then writes back the word it read with only the target bit replaced. All 31 other bits keep the value read.
- R5: The transaction order is fixed. Addresses: engine control 0x200, clamp control 0x10A78C, gate override 0x20004. The bit changes are:
  - 0x200 bit 12 := 0, then a readback of 0x200;
  - 0x200 bit 27 := 1, then wait;
  - 0x10A78C bit 1 := 1, then bit 0 := 1, then bit 0 := 0;
  - 0x20004 bit 31 := 0, then bit 30 := 1, then wait;
  - 0x10A78C bit 1 := 0, then bit 0 := 1, then bit 0 := 0;
  - 0x200 bit 27 := 0;
  - 0x200 bit 12 := 1, then a readback of 0x200.
- R6: The two readback steps of 0x200 issue a read only, with no write following, and their data is discarded.
- R7: At most one strobe is high at a time. While a strobe is high and ready is low, the address, the strobes and the write data hold.
- R8: Each wait lasts the wait count (CLK_HZ/1000*50 cycles, or WAIT_CYCLES_OVR when nonzero) with both strobes low. The gap between the transactions on either side of a wait is between that count and that count plus 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | Write strobe, held until ready |
| bus_re | output | 1 | Read strobe, held until ready |
| bus_rdata | input | 32 | Read data, valid with ready |
| bus_ready | input | 1 | Slave completes the current transaction |

## Verification
The bench builds the block with CLK_HZ at 250 MHz and WAIT_CYCLES_OVR at 20. This shortens each 50 ms wait to twenty cycles, so complete runs fit well inside the cycle budget. It also lets the gap across each wait be bounded tightly. The slave answers with a rotating latency of zero to two cycles, which exercises the hold rules. Several runs start from different register contents, including all-ones and all-zeros words, to show that untouched bits survive. One run is cut short by reset, and another receives a second start while busy.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_STEPS = 16;
    localparam int WAIT_MS   = 50;

    localparam logic [31:0] ADR_ENGINE = 32'h0000_0200;
    localparam logic [31:0] ADR_CLAMP  = 32'h0010_A78C;
    localparam logic [31:0] ADR_GATE   = 32'h0002_0004;

    localparam logic [4:0] BIT_GFX_EN   = 5'd12;
    localparam logic [4:0] BIT_BLK_GATE = 5'd27;
    localparam logic [4:0] BIT_CLMP_MSK = 5'd0;
    localparam logic [4:0] BIT_CLMP_VAL = 5'd1;
    localparam logic [4:0] BIT_OVR_EN   = 5'd30;
    localparam logic [4:0] BIT_OVR_VAL  = 5'd31;

    typedef enum logic [1:0] {
        OP_RMW  = 2'd0,
        OP_READ = 2'd1,
        OP_WAIT = 2'd2
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [31:0] addr;
        logic [4:0]  bitpos;
        logic        val;
    } step_t;

    function automatic step_t mk(op_e op, logic [31:0] a, logic [4:0] b, logic v);
        step_t s;
        s.op     = op;
        s.addr   = a;
        s.bitpos = b;
        s.val    = v;
        return s;
    endfunction

    function automatic step_t step_at(logic [3:0] i);
        case (i)
            4'd0:    return mk(OP_RMW,  ADR_ENGINE, BIT_GFX_EN,   1'b0);
            4'd1:    return mk(OP_READ, ADR_ENGINE, 5'd0,         1'b0);
            4'd2:    return mk(OP_RMW,  ADR_ENGINE, BIT_BLK_GATE, 1'b1);
            4'd3:    return mk(OP_WAIT, 32'h0,      5'd0,         1'b0);
            4'd4:    return mk(OP_RMW,  ADR_CLAMP,  BIT_CLMP_VAL, 1'b1);
            4'd5:    return mk(OP_RMW,  ADR_CLAMP,  BIT_CLMP_MSK, 1'b1);
            4'd6:    return mk(OP_RMW,  ADR_CLAMP,  BIT_CLMP_MSK, 1'b0);
            4'd7:    return mk(OP_RMW,  ADR_GATE,   BIT_OVR_VAL,  1'b0);
            4'd8:    return mk(OP_RMW,  ADR_GATE,   BIT_OVR_EN,   1'b1);
            4'd9:    return mk(OP_WAIT, 32'h0,      5'd0,         1'b0);
            4'd10:   return mk(OP_RMW,  ADR_CLAMP,  BIT_CLMP_VAL, 1'b0);
            4'd11:   return mk(OP_RMW,  ADR_CLAMP,  BIT_CLMP_MSK, 1'b1);
            4'd12:   return mk(OP_RMW,  ADR_CLAMP,  BIT_CLMP_MSK, 1'b0);
            4'd13:   return mk(OP_RMW,  ADR_ENGINE, BIT_BLK_GATE, 1'b0);
            4'd14:   return mk(OP_RMW,  ADR_ENGINE, BIT_GFX_EN,   1'b1);
            default: return mk(OP_READ, ADR_ENGINE, 5'd0,         1'b0);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] put_bit(logic [DATA_W-1:0] w, logic [4:0] b, logic v);
        logic [DATA_W-1:0] m;
        m = {{(DATA_W-1){1'b0}}, 1'b1} << b;
        return (w & ~m) | ({{(DATA_W-1){1'b0}}, v} << b);
    endfunction

endpackage

// File: rtl/pgr_wait_timer.sv
module pgr_wait_timer #(
    parameter int unsigned WAIT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic fin,
    output logic running
);
    localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          run_q;

    assign running = run_q;
    assign fin     = run_q && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt   <= '0;
        end else if (go) begin
            run_q <= 1'b1;
            cnt   <= '0;
        end else if (run_q) begin
            if (cnt == LAST) begin
                run_q <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_fin_running_r8: assert property (@(posedge clk) disable iff (rst)
        fin |=> !running);
endmodule

// File: rtl/pgr_rmw_port.sv
module pgr_rmw_port
    import pgr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  step_t             req,
    output logic              fin,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    typedef enum logic [1:0] { BE_IDLE, BE_RD, BE_WR } be_st_e;

    be_st_e            st;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [4:0]        bit_q;
    logic              val_q;
    logic              rd_only_q;

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign bus_re    = (st == BE_RD);
    assign bus_we    = (st == BE_WR);
    assign fin       = bus_ready && ((st == BE_WR) || (st == BE_RD && rd_only_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= BE_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            bit_q     <= '0;
            val_q     <= 1'b0;
            rd_only_q <= 1'b0;
        end else begin
            case (st)
                BE_IDLE: if (go) begin
                    st        <= BE_RD;
                    addr_q    <= req.addr[ADDR_W-1:0];
                    bit_q     <= req.bitpos;
                    val_q     <= req.val;
                    rd_only_q <= (req.op == OP_READ);
                end
                BE_RD: if (bus_ready) begin
                    if (rd_only_q) begin
                        st <= BE_IDLE;
                    end else begin
                        st      <= BE_WR;
                        wdata_q <= put_bit(bus_rdata, bit_q, val_q);
                    end
                end
                BE_WR: if (bus_ready) st <= BE_IDLE;
                default: st <= BE_IDLE;
            endcase
        end
    end

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_re && bus_we));
    p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
        ((bus_re || bus_we) && !bus_ready) |=>
            ($stable(bus_addr) && $stable(bus_we) && $stable(bus_re) && $stable(bus_wdata)));
    p_write_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_ready && !rd_only_q) |=> (bus_we && $stable(bus_addr)));
    p_read_only_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_ready && rd_only_q) |=> !bus_we);
endmodule

// File: rtl/pgr_seq_ctrl.sv
module pgr_seq_ctrl
    import pgr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  bus_fin,
    input  logic  tmr_fin,
    output logic  bus_go,
    output logic  tmr_go,
    output step_t cur_step,
    output logic  busy,
    output logic  done
);
    localparam int IW = $clog2(NUM_STEPS);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_STEPS - 1);

    typedef enum logic [1:0] { SQ_IDLE, SQ_LAUNCH, SQ_AWAIT } sq_st_e;

    sq_st_e        st;
    logic [IW-1:0] idx;
    logic          fin_any;

    assign cur_step = step_at(4'(idx));
    assign fin_any  = (cur_step.op == OP_WAIT) ? tmr_fin : bus_fin;
    assign bus_go   = (st == SQ_LAUNCH) && (cur_step.op != OP_WAIT);
    assign tmr_go   = (st == SQ_LAUNCH) && (cur_step.op == OP_WAIT);
    assign busy     = (st != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    idx <= '0;
                    st  <= SQ_LAUNCH;
                end
                SQ_LAUNCH: st <= SQ_AWAIT;
                SQ_AWAIT: if (fin_any) begin
                    if (idx == LAST_IDX) begin
                        st   <= SQ_IDLE;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= SQ_LAUNCH;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !fin_any) |=> (idx == $past(idx)));
    p_go_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_go && tmr_go));
endmodule

// File: rtl/pgr_release_seq.sv
module pgr_release_seq
    import pgr_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 250_000_000,
    parameter int unsigned WAIT_CYCLES_OVR = 0,
    parameter int          ADDR_W          = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready
);
    localparam int unsigned DERIVED_WAIT = (CLK_HZ / 1000) * WAIT_MS;
    localparam int unsigned WAIT_CYCLES  = (WAIT_CYCLES_OVR != 0) ? WAIT_CYCLES_OVR : DERIVED_WAIT;

    step_t cur_step;
    logic  bus_go, tmr_go, bus_fin, tmr_fin, tmr_run;

    pgr_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bus_fin  (bus_fin),
        .tmr_fin  (tmr_fin),
        .bus_go   (bus_go),
        .tmr_go   (tmr_go),
        .cur_step (cur_step),
        .busy     (busy),
        .done     (done)
    );

    pgr_rmw_port #(.ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .go        (bus_go),
        .req       (cur_step),
        .fin       (bus_fin),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    pgr_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .go      (tmr_go),
        .fin     (tmr_fin),
        .running (tmr_run)
    );

    p_wait_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_run |-> (!bus_re && !bus_we));
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !bus_re && !bus_we));
    p_strobe_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_re || bus_we) |-> busy);
endmodule

// File: tb/test_pgr_release_seq.sv
module test_pgr_release_seq;

    localparam int W = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        busy, done, bus_we, bus_re;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;

    always #2 clk = ~clk;

    pgr_release_seq #(.CLK_HZ(250_000_000), .WAIT_CYCLES_OVR(W), .ADDR_W(32)) i_pgr_release_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } item_t;
    item_t exp_q[$];

    int n_tests = 0, n_fail = 0;
    logic [31:0] r_eng, r_clmp, r_gate;
    logic [31:0] sh_eng, sh_clmp, sh_gate;

    bit          cap_we;
    logic [31:0] cap_addr, cap_wdata;
    int          lat = 1, lat_idx = 0;
    int          gap = 0, n_long = 0, done_cnt = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] shadow_get(logic [31:0] a);
        if (a == 32'h200) return sh_eng;
        if (a == 32'h10A78C) return sh_clmp;
        return sh_gate;
    endfunction

    task automatic exp_rmw(logic [31:0] a, int b, bit v);
        logic [31:0] w;
        item_t it;
        w = shadow_get(a);
        it.we = 0; it.addr = a; it.data = w; exp_q.push_back(it);
        w[b] = v;
        if (a == 32'h200) sh_eng = w;
        else if (a == 32'h10A78C) sh_clmp = w;
        else sh_gate = w;
        it.we = 1; it.addr = a; it.data = w; exp_q.push_back(it);
    endtask

    task automatic exp_rd(logic [31:0] a);
        item_t it;
        it.we = 0; it.addr = a; it.data = shadow_get(a);
        exp_q.push_back(it);
    endtask

    // Driver: expected log for R5 built from the requirement text
    task automatic build_expected();
        sh_eng = r_eng; sh_clmp = r_clmp; sh_gate = r_gate;
        exp_rmw(32'h200, 12, 0);      exp_rd(32'h200);
        exp_rmw(32'h200, 27, 1);
        exp_rmw(32'h10A78C, 1, 1);    exp_rmw(32'h10A78C, 0, 1); exp_rmw(32'h10A78C, 0, 0);
        exp_rmw(32'h20004, 31, 0);    exp_rmw(32'h20004, 30, 1);
        exp_rmw(32'h10A78C, 1, 0);    exp_rmw(32'h10A78C, 0, 1); exp_rmw(32'h10A78C, 0, 0);
        exp_rmw(32'h200, 27, 0);
        exp_rmw(32'h200, 12, 1);      exp_rd(32'h200);
    endtask

    function automatic logic [31:0] slave_rd(logic [31:0] a);
        if (a == 32'h200) return r_eng;
        if (a == 32'h10A78C) return r_clmp;
        return r_gate;
    endfunction

    // Monitor and slave: pops the expected log on each completed transaction
    task automatic commit();
        item_t e;
        if (exp_q.size() == 0) begin
            check(0, "R2/R5 unexpected transaction", cap_addr, 32'h0);
            return;
        end
        e = exp_q.pop_front();
        check(cap_we == e.we, cap_we ? "R6 op kind (write seen)" : "R4 op kind (read seen)",
              {31'b0, cap_we}, {31'b0, e.we});
        check(cap_addr == e.addr, "R5 address order", cap_addr, e.addr);
        if (cap_we) begin
            check(cap_wdata == e.data, "R4 write-back data", cap_wdata, e.data);
            if (cap_addr == 32'h200) r_eng = cap_wdata;
            else if (cap_addr == 32'h10A78C) r_clmp = cap_wdata;
            else r_gate = cap_wdata;
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            bus_ready = 1'b0;
            lat = 1;
            gap = 0;
        end else begin
            if (bus_re && bus_we) check(0, "R7 both strobes", 32'h1, 32'h0);
            if (done) done_cnt++;
            if (bus_ready) begin
                commit();
                bus_ready = 1'b0;
                lat_idx++;
                lat = lat_idx % 3;
            end
            if (busy && !bus_re && !bus_we) gap++;
            else begin
                if (gap >= W) begin
                    n_long++;
                    check(gap <= W + 3, "R8 wait gap upper", gap, W + 3);
                end
                gap = 0;
            end
            if ((bus_re || bus_we) && !bus_ready) begin
                if (lat == 0) begin
                    bus_ready = 1'b1;
                    cap_we    = bus_we;
                    cap_addr  = bus_addr;
                    cap_wdata = bus_wdata;
                    bus_rdata = slave_rd(bus_addr);
                end else lat--;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_seq(logic [31:0] e0, logic [31:0] c0, logic [31:0] g0, bit extra_start);
        int cyc;
        r_eng = e0; r_clmp = c0; r_gate = g0;
        build_expected();
        done_cnt = 0; n_long = 0;
        pulse_start();
        check(busy === 1'b1, "R3 busy after start", {31'b0, busy}, 32'h1);
        cyc = 0;
        while (busy && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (extra_start && cyc == 40) start = 1'b1;
            if (extra_start && cyc == 41) start = 1'b0;
        end
        check(cyc < 2000, "R3 sequence completes (watchdog)", cyc, 2000);
        repeat (30) @(negedge clk);
        check(done_cnt == 1, "R3 single done pulse", done_cnt, 1);
        check(exp_q.size() == 0, "R5 all transactions seen", exp_q.size(), 0);
        check(n_long == 2, "R8 two timed waits", n_long, 2);
        check(!busy, "R2 no rerun after done", {31'b0, busy}, 32'h0);
        check(r_eng == sh_eng && r_clmp == sh_clmp && r_gate == sh_gate,
              "R4 final register contents", r_gate, sh_gate);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !bus_re && !bus_we, "R1 reset state",
              {28'b0, busy, done, bus_re, bus_we}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !bus_re && !bus_we, "R1 idle after reset",
              {28'b0, busy, done, bus_re, bus_we}, 32'h0);

        run_seq(32'h1234_1FFF, 32'hA5A5_0F00, 32'h8000_00C3, 0);
        run_seq(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_seq(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1);

        // Reset in mid-run (R1)
        r_eng = 32'h0F0F_0F0F; r_clmp = 32'h0; r_gate = 32'h0;
        build_expected();
        pulse_start();
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!busy && !bus_re && !bus_we, "R1 reset mid-run",
              {29'b0, busy, bus_re, bus_we}, 32'h0);
        exp_q.delete();
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !bus_re && !bus_we, "R1 idle after mid-run reset",
              {29'b0, busy, bus_re, bus_we}, 32'h0);

        run_seq(32'h5555_AAAA, 32'h3C3C_C3C3, 32'h4000_0001, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule